// File: doc/BRIEF.md
# Cascaded Wide Counter and Programmable Divider

This block builds a wide synchronous up counter out of a row of identical narrow presettable stages, 8 bits each and four of them by default, for a 32-bit chain. Every stage has its own terminal-count flag, which is active low and falls while all of that stage's bits are ones. A stage's count enable is the OR of the external active-low enable and the terminal-count flags of every stage below it. A stage therefore advances only on an edge where all lower stages are about to wrap. On that same edge the lower stages return to zero and their flags rise again, which puts the stage back into hold.

With the divider mode input high, the chain reloads itself. The OR of all stage terminal-count flags is the divided output. When that output is low and counting is enabled, every stage's parallel load is asserted at once, so the whole chain takes the preset together, and only when the full width is all ones. If the preset is 2^W − R, the output is low for one clock in every R clocks, for any R from 2 to 2^W. An external load input puts the preset into all stages at any time.

Each stage picks one of three modes on every edge: SM_LOAD (parallel load asserted), SM_COUNT (enable low, no load) or SM_HOLD (otherwise). SM_LOAD always takes priority. The transitions are: SM_HOLD to SM_COUNT when the stage's enable falls; SM_COUNT to SM_HOLD when it rises; any mode to SM_LOAD when the external load is asserted or the chain-wide reload fires; and SM_LOAD back to SM_COUNT or SM_HOLD when the load drops. An asynchronous reset clears every stage.

Top module: `wcd_chain`

## Requirements
- R1: While `rst` is high, `count` is zero, every bit of `stage_tc_n` is 1 and `div_out_n` is 1.
- R2: When `load` is high at a rising edge, `count` takes `preset` on that edge, whatever `cnt_en_n` and `div_mode` are.
- R3: When `cnt_en_n` is high and `load` is low, `count` keeps its value across the edge, in both modes.
- R4: When `cnt_en_n` is low, `load` is low and no reload applies, `count` increments by one per edge, with carries passing from each stage into the next.
- R5: `stage_tc_n[i]` is 0 exactly when bits `[8*i+7 : 8*i]` of `count` are all ones. Stage 0 is the least significant.
- R6: With `load` low, stage i > 0 keeps its bits unless `cnt_en_n` is low and `stage_tc_n[i-1:0]` are all 0.
- R7: `div_out_n` is 0 exactly when every bit of `count` is one.
- R8: With `div_mode` = 1, `cnt_en_n` = 0 and `load` = 0, an edge at which `count` is all ones loads `preset` into every stage.
- R9: With `div_mode` = 1, counting enabled and `preset` = 2^W − R, `div_out_n` is low for one cycle in every R cycles, and `count` equals `preset` on the cycle after each low cycle.
- R10: With `div_mode` = 1 and `cnt_en_n` = 1, a chain sitting at all ones neither reloads nor moves.
- R11: With `div_mode` = 0 and counting enabled, `count` wraps from all ones to zero and does not reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high; clears every stage |
| cnt_en_n | input | 1 | Count enable, active low, into the lowest stage and the whole gating network |
| load | input | 1 | Parallel load of `preset` into all stages, active high |
| div_mode | input | 1 | 1: the chain reloads `preset` at full terminal count; 0: free-running wrap |
| preset | input | 32 | Preset / divide value (STAGE_W*N_STAGES) |
| count | output | 32 | Chain count, stage 0 in the low bits |
| stage_tc_n | output | 4 | Per-stage terminal count, active low (N_STAGES) |
| div_out_n | output | 1 | Divided output / chain terminal count, active low |

## Verification
The hardest states to reach are the moments when several upper stages advance together. In a 32-bit chain they occur only once every 2^8, 2^16 or 2^24 clocks of free counting. The stimulus reaches them in a few cycles by loading presets such as 0x00FFFFFE or 0x12FFFFFF, which sit just below a multi-stage carry. It then checks each stage's flag and the carry on the exact edge. Divider periods are measured with presets near the top of the range, including ratios that cross a stage boundary, and a held enable is applied while the chain is parked at all ones.

// File: rtl/wcd_pkg.sv
package wcd_pkg;

    // Per-edge decision taken by each counter stage.
    typedef enum logic [1:0] {
        SM_HOLD  = 2'd0,
        SM_COUNT = 2'd1,
        SM_LOAD  = 2'd2
    } stage_mode_t;

endpackage

// File: rtl/wcd_stage.sv
module wcd_stage #(
    parameter int STAGE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ce_n,
    input  logic               pe,
    input  logic [STAGE_W-1:0] pdata,
    output logic [STAGE_W-1:0] q,
    output logic               tc_n
);
    import wcd_pkg::*;

    stage_mode_t        mode;
    logic [STAGE_W-1:0] q_nxt;

    // Mode selection: a load wins over counting; counting over holding.
    always_comb begin
        if (pe)
            mode = SM_LOAD;
        else if (!ce_n)
            mode = SM_COUNT;
        else
            mode = SM_HOLD;
    end

    // Next-value output logic per mode.
    always_comb begin
        unique case (mode)
            SM_LOAD:  q_nxt = pdata;
            SM_COUNT: q_nxt = q + {{(STAGE_W-1){1'b0}}, 1'b1};
            SM_HOLD:  q_nxt = q;
            default:  q_nxt = q;
        endcase
    end

    // State register with asynchronous clear.
    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            q <= '0;
        else
            q <= q_nxt;
    end

    assign tc_n = ~(&q);

endmodule

// File: rtl/wcd_enable_chain.sv
module wcd_enable_chain #(
    parameter int N_STAGES = 4
) (
    input  logic                cnt_en_n,
    input  logic [N_STAGES-2:0] lower_tc_n,
    output logic [N_STAGES-1:0] stage_ce_n
);
    // Stage 0 sees the external enable alone; each higher stage sees the
    // OR of the enable and every lower stage's terminal-count flag.
    assign stage_ce_n[0] = cnt_en_n;

    for (genvar i = 1; i < N_STAGES; i++) begin : g_gate
        assign stage_ce_n[i] = cnt_en_n | (|lower_tc_n[i-1:0]);
    end

endmodule

// File: rtl/wcd_reload_ctl.sv
module wcd_reload_ctl #(
    parameter int N_STAGES = 4
) (
    input  logic                load,
    input  logic                div_mode,
    input  logic                cnt_en_n,
    input  logic [N_STAGES-1:0] stage_tc_n,
    output logic [N_STAGES-1:0] stage_pe,
    output logic                div_out_n
);
    logic reload;

    // Chain terminal count: low only when every stage is all ones.
    assign div_out_n = |stage_tc_n;

    // One shared reload term, fanned out to every stage's parallel load.
    assign reload = load | (div_mode & ~cnt_en_n & ~div_out_n);

    for (genvar i = 0; i < N_STAGES; i++) begin : g_pe
        assign stage_pe[i] = reload;
    end

endmodule

// File: rtl/wcd_chain.sv
module wcd_chain #(
    parameter int STAGE_W  = 8,
    parameter int N_STAGES = 4,
    localparam int TOTAL_W = STAGE_W * N_STAGES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cnt_en_n,
    input  logic                load,
    input  logic                div_mode,
    input  logic [TOTAL_W-1:0]  preset,
    output logic [TOTAL_W-1:0]  count,
    output logic [N_STAGES-1:0] stage_tc_n,
    output logic                div_out_n
);
    logic [N_STAGES-1:0] stage_ce_n;
    logic [N_STAGES-1:0] stage_pe;

    wcd_enable_chain #(.N_STAGES(N_STAGES)) u_enable (
        .cnt_en_n   (cnt_en_n),
        .lower_tc_n (stage_tc_n[N_STAGES-2:0]),
        .stage_ce_n (stage_ce_n)
    );

    wcd_reload_ctl #(.N_STAGES(N_STAGES)) u_reload (
        .load       (load),
        .div_mode   (div_mode),
        .cnt_en_n   (cnt_en_n),
        .stage_tc_n (stage_tc_n),
        .stage_pe   (stage_pe),
        .div_out_n  (div_out_n)
    );

    for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
        wcd_stage #(.STAGE_W(STAGE_W)) u_stage (
            .clk   (clk),
            .rst   (rst),
            .ce_n  (stage_ce_n[i]),
            .pe    (stage_pe[i]),
            .pdata (preset[i*STAGE_W +: STAGE_W]),
            .q     (count[i*STAGE_W +: STAGE_W]),
            .tc_n  (stage_tc_n[i])
        );
    end

endmodule

// File: rtl/wcd_chain_chk.sv
module wcd_chain_chk #(
    parameter int STAGE_W  = 8,
    parameter int N_STAGES = 4,
    localparam int TOTAL_W = STAGE_W * N_STAGES
) (
    input logic                clk,
    input logic                rst,
    input logic                cnt_en_n,
    input logic                load,
    input logic                div_mode,
    input logic [TOTAL_W-1:0]  preset,
    input logic [TOTAL_W-1:0]  count,
    input logic [N_STAGES-1:0] stage_tc_n,
    input logic                div_out_n
);
    // R1: reset state seen at each edge during reset
    always @(posedge clk) begin
        if (rst) begin
            assert_reset_clear_R1: assert (count == '0 && &stage_tc_n && div_out_n);
        end
    end

    assert_load_takes_preset_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(preset));

    assert_hold_when_disabled_R3: assert property (@(posedge clk) disable iff (rst)
        (cnt_en_n && !load) |=> $stable(count));

    assert_increment_R4: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en_n && !load && !(div_mode && (&count))) |=> count == $past(count) + 1'b1);

    assert_chain_terminal_R7: assert property (@(posedge clk) disable iff (rst)
        div_out_n == !(&count));

    assert_div_reload_R8: assert property (@(posedge clk) disable iff (rst)
        (div_mode && !cnt_en_n && !load && (&count)) |=> count == $past(preset));

    assert_counter_wrap_R11: assert property (@(posedge clk) disable iff (rst)
        (!div_mode && !cnt_en_n && !load && (&count)) |=> count == '0);

    for (genvar i = 0; i < N_STAGES; i++) begin : g_stage_chk
        assert_stage_flag_R5: assert property (@(posedge clk) disable iff (rst)
            stage_tc_n[i] == !(&count[i*STAGE_W +: STAGE_W]));
    end

    for (genvar i = 1; i < N_STAGES; i++) begin : g_gate_chk
        assert_upper_gated_R6: assert property (@(posedge clk) disable iff (rst)
            (!load && (cnt_en_n || (|stage_tc_n[i-1:0])))
            |=> $stable(count[i*STAGE_W +: STAGE_W]));
    end

endmodule

bind wcd_chain wcd_chain_chk #(.STAGE_W(STAGE_W), .N_STAGES(N_STAGES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cnt_en_n   (cnt_en_n),
    .load       (load),
    .div_mode   (div_mode),
    .preset     (preset),
    .count      (count),
    .stage_tc_n (stage_tc_n),
    .div_out_n  (div_out_n)
);

// File: tb/tb_wcd_chain.sv
module tb_wcd_chain;
    localparam int SW = 8;
    localparam int NS = 4;
    localparam int W  = SW * NS;

    logic          clk = 1'b0;
    logic          rst;
    logic          cnt_en_n;
    logic          load;
    logic          div_mode;
    logic [W-1:0]  preset;
    logic [W-1:0]  count;
    logic [NS-1:0] stage_tc_n;
    logic          div_out_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    wcd_chain #(.STAGE_W(SW), .N_STAGES(NS)) dut (
        .clk(clk), .rst(rst), .cnt_en_n(cnt_en_n), .load(load),
        .div_mode(div_mode), .preset(preset), .count(count),
        .stage_tc_n(stage_tc_n), .div_out_n(div_out_n)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance n rising edges; return at the following falling edge.
    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic load_value(input logic [W-1:0] v, input logic dm, input logic en_n);
        preset = v; div_mode = dm; cnt_en_n = en_n; load = 1'b1;
        step(1);
        load = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1; cnt_en_n = 1'b0; load = 1'b0; div_mode = 1'b0; preset = '1;
        step(2);
        chk("R1 count", count, '0);
        chk("R1 stage_tc_n", W'(stage_tc_n), W'({NS{1'b1}}));
        chk("R1 div_out_n", W'(div_out_n), W'(1));
        rst = 1'b0;
    endtask

    task automatic t_load;
        load_value(32'hFFFF_FFFF, 1'b0, 1'b1);
        chk("R2 load while disabled", count, 32'hFFFF_FFFF);
        chk("R7 all ones low", W'(div_out_n), W'(0));
        chk("R5 all stage flags low", W'(stage_tc_n), W'(0));
        load_value(32'h1234_5678, 1'b1, 1'b0);
        chk("R2 load in divider mode", count, 32'h1234_5678);
    endtask

    task automatic t_hold;
        load_value(32'h00AB_CDEF, 1'b0, 1'b1);
        step(3);
        chk("R3 hold", count, 32'h00AB_CDEF);
        div_mode = 1'b1;
        step(2);
        chk("R3 hold divider mode", count, 32'h00AB_CDEF);
    endtask

    task automatic t_count_carry;
        load_value(32'h0000_00FD, 1'b0, 1'b0);
        step(5);
        chk("R4 carry into stage 1", count, 32'h0000_0102);
        load_value(32'h12FF_FFFF, 1'b0, 1'b0);
        chk("R5 flags at 12FFFFFF", W'(stage_tc_n), W'(4'b1000));
        step(1);
        chk("R4 triple carry", count, 32'h1300_0000);
        chk("R7 high when not all ones", W'(div_out_n), W'(1));
    endtask

    task automatic t_stage_gating;
        load_value(32'h00FF_FFFE, 1'b0, 1'b0);
        step(1);
        chk("R5 flags at 00FFFFFF", W'(stage_tc_n), W'(4'b1000));
        cnt_en_n = 1'b1;
        step(2);
        chk("R6 upper stage held while enable high", count, 32'h00FF_FFFF);
        cnt_en_n = 1'b0;
        step(1);
        chk("R6 upper stage advances", count, 32'h0100_0000);
        load_value(32'h0001_FE00, 1'b0, 1'b0);
        step(1);
        chk("R6 stage 1 held while stage 0 not at terminal", count, 32'h0001_FE01);
    endtask

    task automatic t_wrap;
        load_value(32'hFFFF_FFFE, 1'b0, 1'b0);
        step(1);
        chk("R7 low at all ones", W'(div_out_n), W'(0));
        step(1);
        chk("R11 wraps to zero", count, '0);
    endtask

    task automatic t_div_hold;
        load_value(32'hFFFF_FFFF, 1'b1, 1'b1);
        preset = 32'h0000_0042;
        step(2);
        chk("R10 no reload while disabled", count, 32'hFFFF_FFFF);
        chk("R10 output stays low", W'(div_out_n), W'(0));
        cnt_en_n = 1'b0;
        step(1);
        chk("R8 reload on terminal", count, 32'h0000_0042);
    endtask

    task automatic t_divider(input int r);
        logic [W-1:0] p;
        int n;
        p = -W'(r);
        load_value(p, 1'b1, 1'b0);
        for (int rep = 0; rep < 2; rep++) begin
            n = 0;
            while (div_out_n !== 1'b0 && n < r + 4) begin
                step(1);
                n++;
            end
            chk($sformatf("R9 cycles to low, ratio %0d", r), W'(n), W'(r - 1));
            step(1);
            chk($sformatf("R8 reload, ratio %0d", r), count, p);
            chk($sformatf("R9 single low cycle, ratio %0d", r), W'(div_out_n), W'(1));
        end
    endtask

    initial begin
        t_reset;
        t_load;
        t_hold;
        t_count_carry;
        t_stage_gating;
        t_wrap;
        t_div_hold;
        t_divider(2);
        t_divider(3);
        t_divider(113);
        t_divider(300);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule